// File: doc/BRIEF.md
# Boundary-Aligned Video Stream Switch

This block is a crossbar for valid/ready video streams. Each of its outputs carries the beats of exactly one of its inputs, and any number of outputs may carry the same input. Every beat has a data word, an end-of-line flag (`last`) and a start-of-field flag (`user`). Software writes a new input index for each output into a pending register and then sets a commit bit. Each output adopts its pending choice only at a safe point in its current stream, so that no line or field is cut off. The commit bit reads back as set until every output has made the change.

The safe point is a build-time choice. In end-of-line mode an output moves to the new source once a beat flagged `last` has completed its handshake. In start-of-field mode, used for full-protocol streams and for lite streams that are known to run without gaps, the output moves when the old source offers a beat flagged `user`. That beat is left in place and is not taken. In crash mode the move happens one cycle after the commit, whatever the stream is doing.

Back-pressure rules: an input that feeds several outputs is accepted only when every one of those outputs is ready. An output asserts `valid` only when the beat will also be taken at its source, so `out_valid` may depend on the `out_ready` of outputs that share the same input. An input that no output selects can be drained, which keeps its source from stalling. When the ready wiring is built out, the block never pushes back on any input.

Top module: `vid_stream_switch`

## Requirements
- R1: After reset, output o carries input (o mod N_IN), the pending index of each output equals its active index, and the commit bit reads 0.
- R2: Each output presents the data, `last` and `user` of its active input. Its `valid` equals that input's `valid` whenever all outputs sharing the input are ready and no switch is taking place on the output.
- R3: With ready wiring present, a selected input's `in_ready` is the AND of `out_ready` over all outputs whose active input it is. An output's `out_valid` is low while `in_ready` of its input is low.
- R4: An input that no output selects has `in_ready` = 1 when AUTO_DRAIN = 1 and 0 otherwise.
- R5: A write to address o (o < N_OUT) stores `cfg_wdata` as the pending index of output o, unless the value is N_IN or larger, in which case the write is ignored. A read of address o returns that pending index. A write to address N_OUT with bit 0 set starts a commit, and a read of address N_OUT returns the commit state in bit 0.
- R6: In end-of-line mode, a waiting output keeps carrying its old input until a beat with `last` = 1 completes its handshake. From the next cycle it carries the pending input.
- R7: In start-of-field mode, in the cycle where the old input offers a valid beat with `user` = 1, the waiting output drives `out_valid` = 0 and does not count toward that input's ready. From the next cycle it carries the pending input.
- R8: In crash mode, the output has a one-cycle `out_valid` = 0 bubble in the cycle after the commit write edge. It carries the pending input from the cycle after that.
- R9: The commit bit stays 1 until every output has applied its pending index. An output whose pending index already equals its active index applies it at once.
- R10: With HAS_READY = 0, every `in_ready` is 1 whatever the `out_ready` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Per-input beat valid |
| in_ready | output | N_IN | Per-input beat accepted |
| in_data | input | N_IN*DW | Per-input pixel data, input i at bits [i*DW +: DW] |
| in_last | input | N_IN | Per-input end-of-line flag |
| in_user | input | N_IN | Per-input start-of-field flag |
| out_valid | output | N_OUT | Per-output beat valid |
| out_ready | input | N_OUT | Per-output sink ready |
| out_data | output | N_OUT*DW | Per-output pixel data |
| out_last | output | N_OUT | Per-output end-of-line flag |
| out_user | output | N_OUT | Per-output start-of-field flag |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data, combinational on `cfg_addr` |

## Verification
The bench builds three copies with three inputs, two outputs and 16-bit pixels (8-bit samples, two planes, one pixel per beat). The first uses end-of-line switching with drain and ready wiring. With this copy the bench can test shared-input back-pressure, draining of unselected inputs, ignored out-of-range writes and a commit held open by one waiting output. The second uses start-of-field switching, which lets the bench test the stalled flagged beat. The third uses crash switching with the ready wiring built out, which lets the bench test the one-cycle bubble and an input side that never pushes back.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

  typedef enum logic [1:0] {
    BND_EOL = 2'd0,
    BND_SOF = 2'd1,
    BND_NOW = 2'd2
  } bnd_mode_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bnd_mode_e pick_mode(input bit crash, input bit full, input bit unint);
    if (crash) return BND_NOW;
    if (full || unint) return BND_SOF;
    return BND_EOL;
  endfunction

endpackage

// File: rtl/vsw_route_regs.sv
module vsw_route_regs #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int SW    = 2,
  parameter int AW    = 2,
  parameter int CW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  input  logic [N_OUT-1:0]  applied,
  output logic [N_OUT*SW-1:0] pend_flat,
  output logic [N_OUT-1:0]  want,
  output logic [CW-1:0]     cfg_rdata
);

  localparam logic [AW-1:0] COMMIT_ADDR = AW'(N_OUT);
  localparam logic [CW-1:0] NIN_LIM     = CW'(N_IN);

  logic [SW-1:0] pend [N_OUT];
  logic          idx_ok;

  assign idx_ok = (cfg_wdata < NIN_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < N_OUT; o++) pend[o] <= SW'(o % N_IN);
      want <= '0;
    end else begin
      if (cfg_wr && idx_ok) begin
        for (int o = 0; o < N_OUT; o++)
          if (cfg_addr == AW'(o)) pend[o] <= cfg_wdata[SW-1:0];
      end
      if (cfg_wr && cfg_addr == COMMIT_ADDR && cfg_wdata[0])
        want <= '1;
      else
        want <= want & ~applied;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int o = 0; o < N_OUT; o++)
      if (cfg_addr == AW'(o)) cfg_rdata[SW-1:0] = pend[o];
    if (cfg_addr == COMMIT_ADDR) cfg_rdata[0] = |want;
  end

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_flat
      assign pend_flat[o*SW +: SW] = pend[o];
    end
  endgenerate

endmodule

// File: rtl/vsw_ready_net.sv
module vsw_ready_net #(
  parameter int N_IN       = 3,
  parameter int N_OUT      = 2,
  parameter int SW         = 2,
  parameter bit AUTO_DRAIN = 1'b1,
  parameter bit HAS_READY  = 1'b1
) (
  input  logic [N_OUT*SW-1:0] act_flat,
  input  logic [N_OUT-1:0]    swap_now,
  input  logic [N_OUT-1:0]    out_ready,
  output logic [N_IN-1:0]     in_ready
);

  generate
    if (HAS_READY) begin : g_bp
      always_comb begin
        for (int i = 0; i < N_IN; i++) begin
          logic any_sel;
          logic all_rdy;
          any_sel = 1'b0;
          all_rdy = 1'b1;
          for (int o = 0; o < N_OUT; o++) begin
            if (act_flat[o*SW +: SW] == SW'(i)) begin
              any_sel = 1'b1;
              all_rdy = all_rdy & out_ready[o] & ~swap_now[o];
            end
          end
          in_ready[i] = any_sel ? all_rdy : AUTO_DRAIN;
        end
      end
    end else begin : g_nobp
      assign in_ready = '1;
    end
  endgenerate

endmodule

// File: rtl/vsw_out_lane.sv
module vsw_out_lane
  import vsw_pkg::*;
#(
  parameter int        N_IN      = 3,
  parameter int        DW        = 16,
  parameter int        SW        = 2,
  parameter bnd_mode_e BND       = BND_EOL,
  parameter int        RESET_SEL = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    in_valid,
  input  logic [N_IN-1:0]    in_last,
  input  logic [N_IN-1:0]    in_user,
  input  logic [N_IN*DW-1:0] in_data,
  input  logic [N_IN-1:0]    in_ready,
  input  logic               want,
  input  logic [SW-1:0]      pend_sel,
  output logic [SW-1:0]      act_sel,
  output logic               swap_now,
  output logic               applied,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  output logic               out_last,
  output logic               out_user
);

  logic src_valid, src_last, src_user, src_rdy, same_sel;

  always_comb begin
    src_valid = 1'b0;
    src_last  = 1'b0;
    src_user  = 1'b0;
    src_rdy   = 1'b0;
    out_data  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (act_sel == SW'(i)) begin
        src_valid = in_valid[i];
        src_last  = in_last[i];
        src_user  = in_user[i];
        src_rdy   = in_ready[i];
        out_data  = in_data[i*DW +: DW];
      end
    end
  end

  assign same_sel = (pend_sel == act_sel);

  generate
    if (BND == BND_EOL) begin : g_eol
      assign swap_now = 1'b0;
      assign applied  = want & (same_sel | (src_valid & src_rdy & src_last));
    end else if (BND == BND_SOF) begin : g_sof
      assign swap_now = want & ~same_sel & src_valid & src_user;
      assign applied  = want & (same_sel | swap_now);
    end else begin : g_now
      assign swap_now = want & ~same_sel;
      assign applied  = want;
    end
  endgenerate

  assign out_valid = src_valid & src_rdy & ~swap_now;
  assign out_last  = src_last;
  assign out_user  = src_user;

  always_ff @(posedge clk) begin
    if (!rst_n)       act_sel <= SW'(RESET_SEL);
    else if (applied) act_sel <= pend_sel;
  end

endmodule

// File: rtl/vid_stream_switch.sv
module vid_stream_switch
  import vsw_pkg::*;
#(
  parameter int N_IN          = 3,
  parameter int N_OUT         = 2,
  parameter int BPS           = 8,
  parameter int PLANES        = 2,
  parameter int PIX_PAR       = 1,
  parameter bit FULL_MODE     = 1'b0,
  parameter bit UNINTERRUPTED = 1'b0,
  parameter bit CRASH         = 1'b0,
  parameter bit AUTO_DRAIN    = 1'b1,
  parameter bit HAS_READY     = 1'b1,
  parameter int CFG_W         = 8,
  localparam int DW = BPS * PLANES * PIX_PAR,
  localparam int AW = idx_w(N_OUT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     in_valid,
  output logic [N_IN-1:0]     in_ready,
  input  logic [N_IN*DW-1:0]  in_data,
  input  logic [N_IN-1:0]     in_last,
  input  logic [N_IN-1:0]     in_user,
  output logic [N_OUT-1:0]    out_valid,
  input  logic [N_OUT-1:0]    out_ready,
  output logic [N_OUT*DW-1:0] out_data,
  output logic [N_OUT-1:0]    out_last,
  output logic [N_OUT-1:0]    out_user,
  input  logic                cfg_wr,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata
);

  localparam int        SW  = idx_w(N_IN);
  localparam bnd_mode_e BND = pick_mode(CRASH, FULL_MODE, UNINTERRUPTED);

  logic [N_OUT*SW-1:0] pend_flat;
  logic [N_OUT*SW-1:0] act_flat;
  logic [N_OUT-1:0]    want;
  logic [N_OUT-1:0]    applied;
  logic [N_OUT-1:0]    swap_now;

  vsw_route_regs #(
    .N_IN(N_IN), .N_OUT(N_OUT), .SW(SW), .AW(AW), .CW(CFG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .applied(applied), .pend_flat(pend_flat), .want(want),
    .cfg_rdata(cfg_rdata)
  );

  vsw_ready_net #(
    .N_IN(N_IN), .N_OUT(N_OUT), .SW(SW),
    .AUTO_DRAIN(AUTO_DRAIN), .HAS_READY(HAS_READY)
  ) u_rdy (
    .act_flat(act_flat), .swap_now(swap_now),
    .out_ready(out_ready), .in_ready(in_ready)
  );

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
      vsw_out_lane #(
        .N_IN(N_IN), .DW(DW), .SW(SW), .BND(BND), .RESET_SEL(o % N_IN)
      ) u_lane (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_last(in_last), .in_user(in_user),
        .in_data(in_data), .in_ready(in_ready),
        .want(want[o]), .pend_sel(pend_flat[o*SW +: SW]),
        .act_sel(act_flat[o*SW +: SW]), .swap_now(swap_now[o]),
        .applied(applied[o]),
        .out_valid(out_valid[o]), .out_data(out_data[o*DW +: DW]),
        .out_last(out_last[o]), .out_user(out_user[o])
      );
    end
  endgenerate

endmodule

// File: rtl/vsw_switch_chk.sv
module vsw_switch_chk #(
  parameter int N_IN       = 3,
  parameter int N_OUT      = 2,
  parameter int SW         = 2,
  parameter bit AUTO_DRAIN = 1'b1,
  parameter bit HAS_READY  = 1'b1,
  parameter bit EOL_MODE   = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN-1:0]     in_valid,
  input logic [N_IN-1:0]     in_last,
  input logic [N_IN-1:0]     in_ready,
  input logic [N_OUT-1:0]    out_valid,
  input logic [N_OUT-1:0]    out_ready,
  input logic [N_OUT*SW-1:0] act_flat,
  input logic [N_OUT*SW-1:0] pend_flat,
  input logic [N_OUT-1:0]    want
);

  logic [N_OUT-1:0] sel_valid, eol_hs;
  logic [N_IN-1:0]  used;

  always_comb begin
    used = '0;
    for (int o = 0; o < N_OUT; o++) begin
      sel_valid[o] = 1'b0;
      eol_hs[o]    = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (act_flat[o*SW +: SW] == SW'(i)) begin
          used[i]      = 1'b1;
          sel_valid[o] = in_valid[i];
          eol_hs[o]    = in_valid[i] & in_ready[i] & in_last[i];
        end
      end
    end
  end

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      // R5: the active index never leaves the input range
      p_sel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_flat[o*SW +: SW] < SW'(N_IN));
      // R2: an output is valid only when its active source is valid
      p_fwd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> sel_valid[o]);
      // R9: routing is held when no commit is outstanding for the output
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !want[o] |=> $stable(act_flat[o*SW +: SW]));
      if (EOL_MODE) begin : g_eol
        // R6: no move without a completed end-of-line beat
        p_eol_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (want[o] && pend_flat[o*SW +: SW] != act_flat[o*SW +: SW] && !eol_hs[o])
          |=> $stable(act_flat[o*SW +: SW]));
      end
      if (HAS_READY) begin : g_rdy
        for (genvar i = 0; i < N_IN; i++) begin : g_i
          // R3: a shared input is taken only when each sharer is ready
          p_shared_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_flat[o*SW +: SW] == SW'(i) && in_ready[i]) |-> out_ready[o]);
        end
      end
    end
    if (HAS_READY) begin : g_drain
      for (genvar i = 0; i < N_IN; i++) begin : g_i
        // R4: an unselected input follows the drain setting
        p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
          !used[i] |-> (in_ready[i] == AUTO_DRAIN));
      end
    end else begin : g_free
      // R10: no back-pressure without ready wiring
      p_no_bp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        &in_ready);
    end
  endgenerate

endmodule

bind vid_stream_switch vsw_switch_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .SW(SW),
  .AUTO_DRAIN(AUTO_DRAIN), .HAS_READY(HAS_READY),
  .EOL_MODE(BND == vsw_pkg::BND_EOL)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .act_flat(act_flat), .pend_flat(pend_flat), .want(want)
);

// File: tb/test_vid_stream_switch.sv
module test_vid_stream_switch;

  localparam int NI = 3;
  localparam int NO = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NI-1:0]    in_valid, in_last, in_user;
  logic [NI*DW-1:0] in_data;
  logic [NO-1:0]    out_ready;
  logic [1:0]       cfg_addr;
  logic [7:0]       cfg_wdata;
  logic             wr_a, wr_b, wr_c;

  logic [NI-1:0]    rdy_a, rdy_b, rdy_c;
  logic [NO-1:0]    ov_a, ov_b, ov_c, ol_a, ol_b, ol_c, ou_a, ou_b, ou_c;
  logic [NO*DW-1:0] od_a, od_b, od_c;
  logic [7:0]       rd_a, rd_b, rd_c;

  int n_chk = 0;
  int n_fail = 0;

  vid_stream_switch i_vid_stream_switch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .in_last(in_last), .in_user(in_user),
    .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a),
    .out_last(ol_a), .out_user(ou_a), .cfg_wr(wr_a), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a));

  vid_stream_switch #(.UNINTERRUPTED(1'b1)) i_vid_stream_switch_sof (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .in_last(in_last), .in_user(in_user),
    .out_valid(ov_b), .out_ready(out_ready), .out_data(od_b),
    .out_last(ol_b), .out_user(ou_b), .cfg_wr(wr_b), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b));

  vid_stream_switch #(.CRASH(1'b1), .HAS_READY(1'b0)) i_vid_stream_switch_crash (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c),
    .in_data(in_data), .in_last(in_last), .in_user(in_user),
    .out_valid(ov_c), .out_ready(out_ready), .out_data(od_c),
    .out_last(ol_c), .out_user(ou_c), .cfg_wr(wr_c), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_c));

  function automatic logic [31:0] dpat(input int i);
    return 32'(16'hA000 + 16'(i));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int which, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d;
    wr_a = (which == 0); wr_b = (which == 1); wr_c = (which == 2);
    @(posedge clk);
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    check(od_a[0 +: DW] == dpat(0), "R1 out0 source", 32'(od_a[0 +: DW]), dpat(0));
    check(od_a[DW +: DW] == dpat(1), "R1 out1 source", 32'(od_a[DW +: DW]), dpat(1));
    cfg_addr = 2'd2; #1;
    check(rd_a == 8'd0, "R1 commit idle", 32'(rd_a), 0);
    cfg_addr = 2'd1; #1;
    check(rd_a == 8'd1, "R1 pending of out1", 32'(rd_a), 1);
    check(ov_a == 2'b11, "R2 valid forwarded", 32'(ov_a), 3);
    check(rdy_a[2] == 1'b1, "R4 drain unselected", 32'(rdy_a[2]), 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk); out_ready = 2'b10; #1;
    check(rdy_a[0] == 1'b0, "R3 ready follows sink", 32'(rdy_a[0]), 0);
    check(ov_a[0] == 1'b0, "R3 valid held off", 32'(ov_a[0]), 0);
    check(rdy_a[1] == 1'b1, "R3 other input free", 32'(rdy_a[1]), 1);
    out_ready = 2'b11;
  endtask

  task automatic t_regs;
    cfg_write(0, 2'd0, 8'd2);
    cfg_addr = 2'd0; #1;
    check(rd_a == 8'd2, "R5 pending readback", 32'(rd_a), 2);
    cfg_write(0, 2'd0, 8'd3);
    cfg_addr = 2'd0; #1;
    check(rd_a == 8'd2, "R5 out-of-range ignored", 32'(rd_a), 2);
    check(od_a[0 +: DW] == dpat(0), "R5 no move without commit", 32'(od_a[0 +: DW]), dpat(0));
  endtask

  task automatic t_eol;
    cfg_write(0, 2'd2, 8'd1);
    wait_cyc(2);
    cfg_addr = 2'd2; #1;
    check(rd_a == 8'd1, "R9 commit held open", 32'(rd_a), 1);
    check(od_a[0 +: DW] == dpat(0), "R6 old source kept", 32'(od_a[0 +: DW]), dpat(0));
    check(od_a[DW +: DW] == dpat(1), "R9 same index applied", 32'(od_a[DW +: DW]), dpat(1));
    @(negedge clk); in_last[0] = 1'b1; #1;
    check(ol_a[0] == 1'b1, "R2 last forwarded", 32'(ol_a[0]), 1);
    @(negedge clk); in_last[0] = 1'b0; #1;
    check(od_a[0 +: DW] == dpat(2), "R6 moved after last", 32'(od_a[0 +: DW]), dpat(2));
    check(rd_a == 8'd0, "R9 commit cleared", 32'(rd_a), 0);
  endtask

  task automatic t_share;
    cfg_write(0, 2'd1, 8'd2);
    cfg_write(0, 2'd2, 8'd1);
    @(negedge clk); in_last[1] = 1'b1;
    @(negedge clk); in_last[1] = 1'b0; #1;
    check(od_a[DW +: DW] == dpat(2), "R6 out1 moved", 32'(od_a[DW +: DW]), dpat(2));
    out_ready = 2'b01; #1;
    check(rdy_a[2] == 1'b0, "R3 shared AND", 32'(rdy_a[2]), 0);
    check(ov_a[0] == 1'b0, "R3 sharer stalls", 32'(ov_a[0]), 0);
    check(rdy_a[1:0] == 2'b11, "R4 both drained", 32'(rdy_a[1:0]), 3);
    out_ready = 2'b11; #1;
    check(ov_a == 2'b11, "R3 released", 32'(ov_a), 3);
  endtask

  task automatic t_sof;
    cfg_write(1, 2'd0, 8'd1);
    cfg_write(1, 2'd2, 8'd1);
    wait_cyc(2);
    cfg_addr = 2'd2; #1;
    check(od_b[0 +: DW] == dpat(0), "R7 waits for field", 32'(od_b[0 +: DW]), dpat(0));
    check(rd_b == 8'd1, "R9 sof commit open", 32'(rd_b), 1);
    @(negedge clk); in_user[0] = 1'b1; #1;
    check(ov_b[0] == 1'b0, "R7 flagged beat stalled", 32'(ov_b[0]), 0);
    check(rdy_b[0] == 1'b0, "R7 beat not taken", 32'(rdy_b[0]), 0);
    @(negedge clk); in_user[0] = 1'b0; #1;
    check(od_b[0 +: DW] == dpat(1), "R7 moved at field", 32'(od_b[0 +: DW]), dpat(1));
    check(ov_b[0] == 1'b1, "R7 valid again", 32'(ov_b[0]), 1);
    check(rd_b == 8'd0, "R9 sof commit cleared", 32'(rd_b), 0);
  endtask

  task automatic t_crash;
    @(negedge clk); out_ready = 2'b00; #1;
    check(rdy_c == 3'b111, "R10 never pushes back", 32'(rdy_c), 7);
    check(ov_c[0] == 1'b1, "R10 valid without ready", 32'(ov_c[0]), 1);
    out_ready = 2'b11;
    cfg_write(2, 2'd0, 8'd2);
    cfg_write(2, 2'd2, 8'd1);
    check(ov_c[0] == 1'b0, "R8 one-cycle bubble", 32'(ov_c[0]), 0);
    wait_cyc(1);
    check(od_c[0 +: DW] == dpat(2), "R8 immediate move", 32'(od_c[0 +: DW]), dpat(2));
    check(ov_c[0] == 1'b1, "R8 bubble over", 32'(ov_c[0]), 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    in_valid = '1; in_last = '0; in_user = '0; out_ready = '1;
    for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = DW'(dpat(i));
    cfg_addr = '0; cfg_wdata = '0; wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_backpressure();
    t_regs();
    t_eol();
    t_share();
    t_sof();
    t_crash();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule